// File: doc/BRIEF.md
# Security Fault Capture and Interrupt

This block sits beside a memory access filter and collects the security violations it reports. Every blocked access arrives as a one-cycle event with its address, the requesting master's ID, the access's non-secure attribute and the security setting configured for the target block. The first such event after the status bit is cleared is recorded in two capture registers and sets a sticky status bit. Later violations are still blocked by the filter, but they leave the recorded information alone until software clears the status.

The block drives one level-sensitive interrupt, which is asserted while both the status bit and an enable bit are set. Software reaches the block through a simple word-wide register port that only answers secure requests. Software can also force the status bit on through a write-one-to-set register, which is useful for testing the interrupt path. It acknowledges a fault through a write-one-to-clear register.

Top module: `sfc_fault_irq`

## Requirements
- R1: After reset the enable bit is 1, the status bit is 0 and both capture registers read 0, so the interrupt is low.
- R2: The interrupt output is high exactly when the status bit (offset 0x20, bit 0) and the enable bit (offset 0x28, bit 0) are both 1. It follows a register change one clock after the change is written.
- R3: A secure write to offset 0x24 with bit 0 set clears the status bit. A write there with bit 0 at 0 leaves the status bit unchanged.
- R4: A secure write to offset 0x34 with bit 0 set sets the status bit. A write there with bit 0 at 0 leaves the status bit unchanged.
- R5: A violation event that arrives while the status bit is 0 sets the status bit. It loads the access address into the first capture register (offset 0x2C). It loads the second capture register (offset 0x30) with the master ID in bits 15:0, the non-secure attribute in bit 16 and the block's configured security in bit 17, with all other bits 0.
- R6: A violation event that arrives while the status bit is 1 changes neither capture register.
- R7: Reads of offsets 0x24 and 0x34, and of any offset not listed here, return 0.
- R8: A register access without the secure attribute reads 0 and changes no state.
- R9: When a capturing violation and a clear write fall in the same cycle, the capture wins: the status ends at 1 and the new fault is recorded. A capturing violation together with a set write records the fault and leaves the status at 1.
- R10: Only bit 0 of the enable register is stored. Its other bits, and bits 31:1 of the status register, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_en | input | 1 | Register access request this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 12 | Byte offset of the register (word aligned) |
| reg_wdata | input | 32 | Write data |
| reg_secure | input | 1 | Access carries the secure attribute |
| reg_rdata | output | 32 | Read data, combinational, valid in the request cycle |
| flt_valid | input | 1 | One-cycle blocked-access event |
| flt_addr | input | 32 | Address of the blocked access |
| flt_master | input | 16 | Master ID of the blocked access |
| flt_nonsec | input | 1 | Blocked access was non-secure |
| flt_cfg_ns | input | 1 | Target block is configured non-secure |
| irq | output | 1 | Level interrupt |

## Verification
A wrong status bit shows on the interrupt pin one clock after the event or write that produced it, as long as the enable bit is set. It also shows at once on a status read. Wrong capture contents only show through reads of the capture registers. For that reason the bench reads them often, both right after a fault and after later faults that must not overwrite them. Coincident events, such as a capture together with a clear or a set, are driven on purpose, because a wrong priority there leaves the wrong status and the wrong record in the very next cycle.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int unsigned SFC_REG_AW = 12;
    localparam int unsigned SFC_DW     = 32;
    localparam int unsigned SFC_MID_W  = 16;

    // Register offsets decoded by software drivers
    localparam logic [SFC_REG_AW-1:0] OFF_STATUS = 12'h020;
    localparam logic [SFC_REG_AW-1:0] OFF_CLEAR  = 12'h024;
    localparam logic [SFC_REG_AW-1:0] OFF_ENABLE = 12'h028;
    localparam logic [SFC_REG_AW-1:0] OFF_INFO1  = 12'h02C;
    localparam logic [SFC_REG_AW-1:0] OFF_INFO2  = 12'h030;
    localparam logic [SFC_REG_AW-1:0] OFF_SET    = 12'h034;

    // Decoded write strobes from the register port
    typedef struct packed {
        logic clr;
        logic set;
        logic en_wr;
        logic en_val;
    } sfc_wr_t;

    // Packed layout of the second capture word
    typedef struct packed {
        logic [SFC_DW-19:0]    rsvd;
        logic                  cfg_ns;
        logic                  nonsec;
        logic [SFC_MID_W-1:0]  master;
    } sfc_info2_t;
endpackage

// File: rtl/sfc_regif.sv
module sfc_regif
    import sfc_pkg::*;
(
    input  logic                  reg_en,
    input  logic                  reg_wr,
    input  logic [SFC_REG_AW-1:0] reg_addr,
    input  logic [SFC_DW-1:0]     reg_wdata,
    input  logic                  reg_secure,
    input  logic                  status_q,
    input  logic                  enable_q,
    input  logic [SFC_DW-1:0]     info1_q,
    input  logic [SFC_DW-1:0]     info2_q,
    output sfc_wr_t               wr_o,
    output logic [SFC_DW-1:0]     rdata_o
);
    localparam int unsigned WA = SFC_REG_AW - 2;

    logic            acc_ok;
    logic [WA-1:0]   word;

    assign acc_ok = reg_en && reg_secure;
    assign word   = reg_addr[SFC_REG_AW-1:2];

    function automatic logic hit(input logic [WA-1:0] w, input logic [SFC_REG_AW-1:0] off);
        return w == off[SFC_REG_AW-1:2];
    endfunction

    always_comb begin
        wr_o        = '0;
        wr_o.en_val = reg_wdata[0];
        if (acc_ok && reg_wr) begin
            wr_o.clr   = hit(word, OFF_CLEAR) && reg_wdata[0];
            wr_o.set   = hit(word, OFF_SET)   && reg_wdata[0];
            wr_o.en_wr = hit(word, OFF_ENABLE);
        end
    end

    always_comb begin
        rdata_o = '0;
        if (acc_ok && !reg_wr) begin
            if (hit(word, OFF_STATUS))      rdata_o = {{(SFC_DW-1){1'b0}}, status_q};
            else if (hit(word, OFF_ENABLE)) rdata_o = {{(SFC_DW-1){1'b0}}, enable_q};
            else if (hit(word, OFF_INFO1))  rdata_o = info1_q;
            else if (hit(word, OFF_INFO2))  rdata_o = info2_q;
        end
    end

    // R8: without the secure attribute no strobe may fire
    always_comb begin
        if (reg_en && !reg_secure)
            a_nonsec_quiet_r8: assert (!wr_o.clr && !wr_o.set && !wr_o.en_wr && rdata_o == '0);
    end
endmodule

// File: rtl/sfc_capture.sv
module sfc_capture
    import sfc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  sfc_wr_t              wr_i,
    input  logic                 flt_valid,
    input  logic [ADDR_W-1:0]    flt_addr,
    input  logic [SFC_MID_W-1:0] flt_master,
    input  logic                 flt_nonsec,
    input  logic                 flt_cfg_ns,
    output logic                 status_o,
    output logic                 enable_o,
    output logic [SFC_DW-1:0]    info1_o,
    output logic [SFC_DW-1:0]    info2_o
);
    typedef struct packed {
        logic              status;
        logic              enable;
        logic [SFC_DW-1:0] info1;
        sfc_info2_t        info2;
    } state_t;

    state_t            st_d, st_q;
    logic [SFC_DW-1:0] addr_ext;
    logic              capture;

    generate
        if (ADDR_W < SFC_DW) begin : g_pad
            assign addr_ext = {{(SFC_DW-ADDR_W){1'b0}}, flt_addr};
        end else begin : g_trunc
            assign addr_ext = flt_addr[SFC_DW-1:0];
        end
    endgenerate

    assign capture = flt_valid && !st_q.status;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.status       = 1'b1;
            st_d.info1        = addr_ext;
            st_d.info2        = '0;
            st_d.info2.master = flt_master;
            st_d.info2.nonsec = flt_nonsec;
            st_d.info2.cfg_ns = flt_cfg_ns;
        end else if (wr_i.clr) begin
            st_d.status = 1'b0;
        end
        if (wr_i.set) st_d.status = 1'b1;
        if (wr_i.en_wr) st_d.enable = wr_i.en_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.enable <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
    assign enable_o = st_q.enable;
    assign info1_o  = st_q.info1;
    assign info2_o  = st_q.info2;

    p_capture_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !status_o) |=> (status_o && info1_o == $past(addr_ext)));
    p_hold_info_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_o |=> ($stable(info1_o) && $stable(info2_o)));
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i.clr && !flt_valid) |=> !status_o);
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o && !wr_i.clr) |=> status_o);
    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i.set |=> status_o);
    p_capture_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !status_o && wr_i.clr) |=> status_o);
    p_info2_rsvd_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(info2_o) |-> (info2_o[SFC_DW-1:18] == '0));
endmodule

// File: rtl/sfc_fault_irq.sv
module sfc_fault_irq
    import sfc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_en,
    input  logic                  reg_wr,
    input  logic [SFC_REG_AW-1:0] reg_addr,
    input  logic [SFC_DW-1:0]     reg_wdata,
    input  logic                  reg_secure,
    output logic [SFC_DW-1:0]     reg_rdata,
    input  logic                  flt_valid,
    input  logic [ADDR_W-1:0]     flt_addr,
    input  logic [SFC_MID_W-1:0]  flt_master,
    input  logic                  flt_nonsec,
    input  logic                  flt_cfg_ns,
    output logic                  irq
);
    sfc_wr_t           wr;
    logic              status_q, enable_q;
    logic [SFC_DW-1:0] info1_q, info2_q;

    sfc_regif u_regif (
        .reg_en    (reg_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_secure(reg_secure),
        .status_q  (status_q),
        .enable_q  (enable_q),
        .info1_q   (info1_q),
        .info2_q   (info2_q),
        .wr_o      (wr),
        .rdata_o   (reg_rdata)
    );

    sfc_capture #(.ADDR_W(ADDR_W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr),
        .flt_valid (flt_valid),
        .flt_addr  (flt_addr),
        .flt_master(flt_master),
        .flt_nonsec(flt_nonsec),
        .flt_cfg_ns(flt_cfg_ns),
        .status_o  (status_q),
        .enable_o  (enable_q),
        .info1_o   (info1_q),
        .info2_o   (info2_q)
    );

    assign irq = status_q && enable_q;

    p_irq_needs_enable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.en_wr && !wr.en_val) |=> !irq);
    p_irq_on_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.set && enable_q) |=> irq);
endmodule

// File: tb/sim_sfc_fault_irq.sv
module sim_sfc_fault_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_en = 0, reg_wr = 0, reg_secure = 0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        flt_valid = 0, flt_nonsec = 0, flt_cfg_ns = 0;
    logic [31:0] flt_addr = '0;
    logic [15:0] flt_master = '0;
    logic        irq;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    // model state
    bit        m_st, m_en;
    bit [31:0] m_i1, m_i2;

    always #2 clk = ~clk;

    sfc_fault_irq u0 (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_secure(reg_secure),
        .reg_rdata(reg_rdata), .flt_valid(flt_valid), .flt_addr(flt_addr),
        .flt_master(flt_master), .flt_nonsec(flt_nonsec), .flt_cfg_ns(flt_cfg_ns),
        .irq(irq)
    );

    function automatic bit [31:0] model_read(input bit [11:0] a, input bit sec);
        if (!sec) return 0;
        case (a)
            12'h020: return {31'b0, m_st};
            12'h028: return {31'b0, m_en};
            12'h02C: return m_i1;
            12'h030: return m_i2;
            default: return 0;
        endcase
    endfunction

    task automatic check(input bit [31:0] act, input bit [31:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one cycle; entered and left just after a falling edge
    task automatic step(input bit en, input bit wr, input bit [11:0] a, input bit [31:0] d,
                        input bit sec, input bit v, input bit [31:0] va, input bit [15:0] vm,
                        input bit vn, input bit vc, input string tag);
        bit cap;
        reg_en = en; reg_wr = wr; reg_addr = a; reg_wdata = d; reg_secure = sec;
        flt_valid = v; flt_addr = va; flt_master = vm; flt_nonsec = vn; flt_cfg_ns = vc;
        #1;
        if (en && !wr) check(reg_rdata, model_read(a, sec), tag);
        @(posedge clk);
        cap = v && !m_st;
        if (cap) begin
            m_i1 = va; m_i2 = {14'b0, vc, vn, vm}; m_st = 1;
        end else if (en && wr && sec && a == 12'h024 && d[0]) m_st = 0;
        if (en && wr && sec && a == 12'h034 && d[0]) m_st = 1;
        if (en && wr && sec && a == 12'h028) m_en = d[0];
        @(negedge clk);
        reg_en = 0; flt_valid = 0;
        check({31'b0, irq}, {31'b0, m_st & m_en}, {tag, " irq R2"});
    endtask

    task automatic rd(input bit [11:0] a, input string tag);
        step(1, 0, a, 0, 1, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic wrt(input bit [11:0] a, input bit [31:0] d, input string tag);
        step(1, 1, a, d, 1, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic flt(input bit [31:0] va, input bit [15:0] vm, input bit vn, input bit vc, input string tag);
        step(0, 0, 0, 0, 1, 1, va, vm, vn, vc, tag);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        m_st = 0; m_en = 1; m_i1 = 0; m_i2 = 0;
        repeat (3) @(negedge clk);
        check({31'b0, irq}, 0, "R1 irq after reset");
        rst_n = 1;
        @(negedge clk);
        rd(12'h020, "R1 status"); rd(12'h028, "R1 enable");
        rd(12'h02C, "R1 info1"); rd(12'h030, "R1 info2");
        // R5 first capture
        flt(32'hDEAD_BEE0, 16'hA5C3, 1, 0, "R5 capture");
        rd(12'h02C, "R5 info1"); rd(12'h030, "R5 info2");
        check({31'b0, irq}, 1, "R2 irq after capture");
        // R6 later fault ignored
        flt(32'h1234_5670, 16'h0F0F, 0, 1, "R6 second fault");
        rd(12'h02C, "R6 info1 held"); rd(12'h030, "R6 info2 held");
        // R3 clear with bit0 = 0 does nothing, then with 1
        wrt(12'h024, 32'hFFFF_FFFE, "R3 clear zero");
        rd(12'h020, "R3 status kept");
        wrt(12'h024, 32'h1, "R3 clear one");
        rd(12'h020, "R3 status cleared");
        // R7 write-only registers read zero
        rd(12'h024, "R7 clear reads 0"); rd(12'h034, "R7 set reads 0");
        rd(12'h040, "R7 unused reads 0");
        // R4 set
        wrt(12'h034, 32'h2, "R4 set zero");
        rd(12'h020, "R4 status still 0");
        wrt(12'h034, 32'h1, "R4 set one");
        rd(12'h020, "R4 status set");
        // R2 enable off masks irq
        wrt(12'h028, 32'hFFFF_FFFE, "R2 enable off");
        check({31'b0, irq}, 0, "R2 irq masked");
        // R10 enable only bit0
        wrt(12'h028, 32'hFFFF_FFFF, "R10 enable all ones");
        rd(12'h028, "R10 enable reads 1");
        // R8 non-secure access
        step(1, 0, 12'h020, 0, 0, 0, 0, 0, 0, 0, "R8 nonsec read");
        step(1, 1, 12'h024, 1, 0, 0, 0, 0, 0, 0, "R8 nonsec clear");
        rd(12'h020, "R8 status unchanged");
        step(1, 1, 12'h028, 0, 0, 0, 0, 0, 0, 0, "R8 nonsec enable");
        rd(12'h028, "R8 enable unchanged");
        // R9 capture and clear together
        wrt(12'h024, 1, "R9 prep clear");
        step(1, 1, 12'h024, 1, 1, 1, 32'h0000_8000, 16'h0042, 0, 1, "R9 capture+clear");
        rd(12'h020, "R9 status set"); rd(12'h02C, "R9 info1 new"); rd(12'h030, "R9 info2 new");
        // R9 set together with capture
        wrt(12'h024, 1, "R9 prep clear 2");
        step(1, 1, 12'h034, 1, 1, 1, 32'h0BAD_0000, 16'hFFFF, 1, 1, "R9 capture+set");
        rd(12'h02C, "R9 info1 set case"); rd(12'h030, "R9 info2 set case");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            bit [11:0] a;
            bit [31:0] d;
            int op;
            op = $urandom_range(0, 9);
            a  = 12'h020 + 12'($urandom_range(0, 6) * 4);
            d  = $urandom();
            if (op < 3) d[0] = ($urandom_range(0, 3) != 0);
            step(op < 6, op < 3, a, d, $urandom_range(0, 7) != 0,
                 $urandom_range(0, 3) == 0, $urandom(), 16'($urandom()),
                 1'($urandom()), 1'($urandom()), "R5 R6 R3 R4 random");
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule